// File: doc/BRIEF.md
# Translation table base decoder

This block sits at the start of a stage 1 table walk. It takes a 64-bit translation-base register value together with the current configuration and produces the values the walker needs for its first fetch: a 52-bit table base address, the effective address space identifier, the common-not-private bit, an address size fault flag and a flag for reserved bits that are set. The configuration inputs are a 3-bit physical address size code, the alignment index x, a flag that the system supports 52-bit physical addresses, a flag for the large physical address feature, the identifier width and a flag for the common-not-private feature. The block does not sequence the walk, store translations or derive x from the granule.

The block is one registered stage. A request is decoded in the same cycle it arrives, and the result is captured at the next clock edge. A two-state machine tracks the output valid. `ST_IDLE` means no response is presented. `ST_RESP` means a response is presented. The transitions are as follows:
- *accept*: `ST_IDLE` to `ST_RESP` on a request.
- *chain*: `ST_RESP` to `ST_RESP` on a back-to-back request.
- *drain*: `ST_RESP` to `ST_IDLE` when no request arrives.

A synchronous reset forces `ST_IDLE`. The result fields hold their last values while no request arrives.

Top module: `ttb_decode`

## Requirements
- R1: `rsp_valid` is 1 in the cycle after a cycle with `req_valid` = 1 and 0 in the cycle after a cycle with `req_valid` = 0. During and after synchronous reset it is 0 until the first request.
- R2: Define xc as the clamped alignment index from R3. Base bits [47:xc] equal register bits [47:xc], and base bits [xc-1:0] are 0.
- R3: The alignment index is clamped before use. An `align_x` below 6 acts as 6, and an `align_x` above 48 acts as 48. The base address is therefore always aligned to at least 64 bytes.
- R4: Wide mode holds when `lpa_en` = 1 and `pa_code` = 3'b110. In wide mode, base bits [51:48] equal register bits [5:2]. In every other case they are 0.
- R5: Outside wide mode, `rsp_rsv` = 1 exactly when any register bit in [xc-1:1] is 1.
- R6: In wide mode, `rsp_rsv` = 1 exactly when register bit 1 is 1 or any register bit in [xc-1:6] is 1. Register bits [5:2] never count as reserved in this mode.
- R7: `rsp_asf` = 1 exactly when `pa52_ok` = 0, `pa_code` = 3'b110 and register bits [5:2] are nonzero. This holds regardless of `lpa_en`.
- R8: `rsp_asid` equals register bits [63:48] when `asid16` = 1. When `asid16` = 0, its upper 8 bits are 0 and its lower 8 bits equal register bits [55:48].
- R9: `rsp_cnp` equals register bit 0 when `cnp_en` = 1 and is 0 when `cnp_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Decode request for this cycle |
| req_reg | input | 64 | Translation-base register value |
| pa_code | input | 3 | Physical address size code; 3'b110 selects 52 bits |
| align_x | input | 6 | Alignment index x (clamped to 6..48) |
| pa52_ok | input | 1 | System supports 52-bit physical addresses |
| lpa_en | input | 1 | Large physical address feature present |
| asid16 | input | 1 | 1: 16-bit identifier, 0: 8-bit identifier |
| cnp_en | input | 1 | Common-not-private feature present |
| rsp_valid | output | 1 | Response valid |
| rsp_base | output | 52 | Table base address |
| rsp_asid | output | 16 | Effective address space identifier |
| rsp_cnp | output | 1 | Common-not-private bit |
| rsp_asf | output | 1 | Address size fault |
| rsp_rsv | output | 1 | Reserved register bit set |

## Verification
The assertions assume that every configuration input is steady in the cycle in which `req_valid` is high. Under that assumption, the properties that relate a request to the next cycle's result are meaningful. They assume nothing about `align_x`, because clamping is part of the checked behaviour. For that reason the stimulus draws `align_x` over its whole 6-bit range. It biases `pa_code` toward 3'b110 so that wide mode and the fault case come up often. Inputs change only on falling edges.

// File: rtl/ttbd_pkg.sv
package ttbd_pkg;
    localparam int REG_W     = 64;
    localparam int PA_W      = 52;
    localparam int VA_HI     = 48;
    localparam int ASID_W    = 16;
    localparam int XW        = 6;
    localparam int X_MIN     = 6;
    localparam int HI_W      = PA_W - VA_HI;
    localparam int HI_SRC_LO = 2;
    localparam logic [2:0] PA_CODE_WIDE = 3'b110;

    typedef struct packed {
        logic [PA_W-1:0]   base;
        logic [ASID_W-1:0] asid;
        logic              cnp;
        logic              asf;
        logic              rsv;
    } walk_start_t;

    typedef enum logic {ST_IDLE, ST_RESP} stage_state_t;
endpackage

// File: rtl/ttbd_align.sv
module ttbd_align
    import ttbd_pkg::*;
(
    input  logic [XW-1:0]    align_x,
    output logic [VA_HI-1:0] below_x
);
    localparam logic [XW-1:0] LO_LIM = XW'(X_MIN);
    localparam logic [XW-1:0] HI_LIM = XW'(VA_HI);

    logic [XW-1:0] xc;

    always_comb begin
        if (align_x < LO_LIM)
            xc = LO_LIM;
        else if (align_x > HI_LIM)
            xc = HI_LIM;
        else
            xc = align_x;
    end

    // One comparator per address bit: set when the bit lies below xc.
    for (genvar i = 0; i < VA_HI; i++) begin : g_mask
        assign below_x[i] = (XW'(i) < xc);
    end
endmodule

// File: rtl/ttbd_fields.sv
module ttbd_fields
    import ttbd_pkg::*;
(
    input  logic [REG_W-1:0] req_reg,
    input  logic [2:0]       pa_code,
    input  logic [VA_HI-1:0] below_x,
    input  logic             pa52_ok,
    input  logic             lpa_en,
    input  logic             asid16,
    input  logic             cnp_en,
    output walk_start_t      fields
);
    localparam int HALF = ASID_W / 2;

    logic             wide;
    logic [VA_HI-1:0] rsv_mask;

    assign wide = lpa_en && (pa_code == PA_CODE_WIDE);

    always_comb begin
        rsv_mask    = below_x;
        rsv_mask[0] = 1'b0;
        if (wide)
            rsv_mask[HI_SRC_LO +: HI_W] = '0;
    end

    always_comb begin
        fields.base[VA_HI-1:0]    = req_reg[VA_HI-1:0] & ~below_x;
        fields.base[PA_W-1:VA_HI] = wide ? req_reg[HI_SRC_LO +: HI_W] : '0;
        fields.asid               = req_reg[REG_W-1 -: ASID_W];
        if (!asid16)
            fields.asid[ASID_W-1:HALF] = '0;
        fields.cnp = cnp_en & req_reg[0];
        fields.asf = !pa52_ok && (pa_code == PA_CODE_WIDE) &&
                     (|req_reg[HI_SRC_LO +: HI_W]);
        fields.rsv = |(req_reg[VA_HI-1:0] & rsv_mask);
    end
endmodule

// File: rtl/ttbd_stage.sv
module ttbd_stage
    import ttbd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  walk_start_t d,
    output logic        rsp_valid,
    output walk_start_t q
);
    stage_state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        rsp_valid = (state_q == ST_RESP);
    end

    always_ff @(posedge clk) begin
        if (req_valid)
            q <= d;
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R1
endmodule

// File: rtl/ttb_decode.sv
module ttb_decode
    import ttbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [REG_W-1:0] req_reg,
    input  logic [2:0]       pa_code,
    input  logic [XW-1:0]    align_x,
    input  logic             pa52_ok,
    input  logic             lpa_en,
    input  logic             asid16,
    input  logic             cnp_en,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_base,
    output logic [ASID_W-1:0] rsp_asid,
    output logic             rsp_cnp,
    output logic             rsp_asf,
    output logic             rsp_rsv
);
    logic [VA_HI-1:0] below_x;
    walk_start_t      dec, held;

    ttbd_align u_align (
        .align_x (align_x),
        .below_x (below_x)
    );

    ttbd_fields u_fields (
        .req_reg (req_reg),
        .pa_code (pa_code),
        .below_x (below_x),
        .pa52_ok (pa52_ok),
        .lpa_en  (lpa_en),
        .asid16  (asid16),
        .cnp_en  (cnp_en),
        .fields  (dec)
    );

    ttbd_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .d         (dec),
        .rsp_valid (rsp_valid),
        .q         (held)
    );

    assign rsp_base = held.base;
    assign rsp_asid = held.asid;
    assign rsp_cnp  = held.cnp;
    assign rsp_asf  = held.asf;
    assign rsp_rsv  = held.rsv;

    AST_BASE_MIN_ALIGN: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_base[X_MIN-1:0] == '0)); // R3
    AST_HI_ZERO_NARROW: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(lpa_en && pa_code == PA_CODE_WIDE)) |=>
        (rsp_base[PA_W-1:VA_HI] == '0)); // R4
    AST_ASF_SUPPORTED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pa52_ok) |=> !rsp_asf); // R7
    AST_ASID_NARROW: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !asid16) |=> (rsp_asid[ASID_W-1:ASID_W/2] == '0)); // R8
    AST_CNP_ABSENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cnp_en) |=> !rsp_cnp); // R9
endmodule

// File: tb/sim_ttb_decode.sv
`timescale 1ns/1ps
module sim_ttb_decode;
    import ttbd_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_reg;
    logic [2:0]  pa_code;
    logic [5:0]  align_x;
    logic        pa52_ok, lpa_en, asid16, cnp_en;
    logic        rsp_valid;
    logic [51:0] rsp_base;
    logic [15:0] rsp_asid;
    logic        rsp_cnp, rsp_asf, rsp_rsv;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ttb_decode u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_reg(req_reg),
        .pa_code(pa_code), .align_x(align_x), .pa52_ok(pa52_ok),
        .lpa_en(lpa_en), .asid16(asid16), .cnp_en(cnp_en),
        .rsp_valid(rsp_valid), .rsp_base(rsp_base), .rsp_asid(rsp_asid),
        .rsp_cnp(rsp_cnp), .rsp_asf(rsp_asf), .rsp_rsv(rsp_rsv)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic walk_start_t model(input logic [63:0] r, input logic [2:0] code,
                                          input logic [5:0] x, input logic p52,
                                          input logic lpa, input logic a16, input logic cp);
        walk_start_t e;
        int xc;
        logic wide;
        xc = (x < 6) ? 6 : ((x > 48) ? 48 : int'(x));
        wide = lpa && (code == 3'b110);
        e = '0;
        for (int i = 0; i < 48; i++)
            if (i >= xc) e.base[i] = r[i];
        if (wide) e.base[51:48] = r[5:2];
        for (int i = 1; i < 48; i++)
            if (i < xc && (!wide || i == 1 || i >= 6))
                e.rsv = e.rsv | r[i];
        e.asid = a16 ? r[63:48] : {8'h00, r[55:48]};
        e.cnp  = cp & r[0];
        e.asf  = !p52 && (code == 3'b110) && (r[5:2] != 4'h0);
        return e;
    endfunction

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic txn(input logic [63:0] r, input logic [2:0] code, input logic [5:0] x,
                       input logic p52, input logic lpa, input logic a16, input logic cp,
                       input string base_tag);
        walk_start_t e;
        logic wide;
        req_valid = 1'b1; req_reg = r; pa_code = code; align_x = x;
        pa52_ok = p52; lpa_en = lpa; asid16 = a16; cnp_en = cp;
        e = model(r, code, x, p52, lpa, a16, cp);
        wide = lpa && (code == 3'b110);
        @(negedge clk);
        check("R1 valid", 64'(rsp_valid), 64'd1);
        check(base_tag, 64'(rsp_base[47:0]), 64'(e.base[47:0]));
        check("R4 base_hi", 64'(rsp_base[51:48]), 64'(e.base[51:48]));
        check(wide ? "R6 rsv_wide" : "R5 rsv", 64'(rsp_rsv), 64'(e.rsv));
        check("R7 asf", 64'(rsp_asf), 64'(e.asf));
        check("R8 asid", 64'(rsp_asid), 64'(e.asid));
        check("R9 cnp", 64'(rsp_cnp), 64'(e.cnp));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; req_valid = 1'b0; req_reg = '0; pa_code = '0; align_x = 6'd12;
        pa52_ok = 1'b0; lpa_en = 1'b0; asid16 = 1'b1; cnp_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", 64'(rsp_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle_after_reset", 64'(rsp_valid), 64'd0);

        // Directed corners
        txn(64'hFFFF_FFFF_FFFF_FFFF, 3'b101, 6'd0,  1, 0, 1, 1, "R3 clamp_low");
        txn(64'hFFFF_FFFF_FFFF_FFFE, 3'b101, 6'd63, 1, 0, 0, 0, "R3 clamp_high");
        txn(64'h1234_8000_0000_1000, 3'b010, 6'd12, 1, 0, 1, 1, "R2 base");
        txn(64'h0000_0000_0000_1028, 3'b110, 6'd12, 1, 1, 1, 0, "R2 base_wide");
        txn(64'h0000_0000_0000_003C, 3'b110, 6'd6,  1, 1, 1, 1, "R2 wide_no_rsv");
        txn(64'h0000_0000_0000_0002, 3'b110, 6'd6,  1, 1, 1, 1, "R2 wide_bit1");
        txn(64'h0000_0000_0000_0014, 3'b110, 6'd20, 0, 1, 1, 1, "R2 asf_wide");
        txn(64'h0000_0000_0000_0004, 3'b110, 6'd20, 0, 0, 1, 1, "R2 asf_nolpa");
        txn(64'hABCD_0000_0000_0001, 3'b000, 6'd48, 1, 0, 0, 1, "R2 x48");

        req_valid = 1'b0;
        @(negedge clk);
        check("R1 drain", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        check("R1 stay_idle", 64'(rsp_valid), 64'd0);

        for (int n = 0; n < 400; n++) begin
            logic [63:0] r;
            logic [2:0]  code;
            r = {$urandom(), $urandom()};
            if ($urandom() % 4 == 0) r = r & ~((64'd1 << ($urandom() % 48)) - 64'd1);
            code = ($urandom() % 2 == 0) ? 3'b110 : 3'($urandom());
            txn(r, code, 6'($urandom()), 1'($urandom()), 1'($urandom()),
                1'($urandom()), 1'($urandom()), "R2 rand_base");
            if ($urandom() % 8 == 0) begin
                req_valid = 1'b0;
                @(negedge clk);
                check("R1 gap", 64'(rsp_valid), 64'd0);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule